// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Controller

This block holds the two byte queues of one serial-port channel: a receive queue filled by the receive shifter and drained by host reads, and a transmit queue filled by host writes and drained by the transmit shifter. A single write-only control byte enables both queues, flushes either one, picks how the two ready outputs behave, and chooses the receive fill level at which the receive-data interrupt fires. The shifters, baud timing and line control sit outside the block.

When the queues are disabled, each direction behaves as a one-byte holding register. When they are enabled, each holds `DEPTH` bytes (16 by default). Pops are registered: the popped byte appears on the data output in the cycle after the pop. The control byte's bit positions are decoded as described below, because software writes them directly.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, both queues are disabled and empty. The levels are 0, `rx_irq`, `rx_rdy` and `rx_overrun` are 0, and `tx_rdy` is 1.
- R2: When enabled, each queue holds up to `DEPTH` bytes and returns them in arrival order. A popped byte appears on the pop data output one cycle after the pop.
- R3: A control write with bit 0 clear programs nothing else. With the queues disabled, writing bits 3, 6 and 7 has no effect: the interrupt still fires at one byte and the ready outputs keep their normal behaviour.
- R4: A control write with bits 0 and 1 both set empties the receive queue and leaves the transmit queue alone. The flush happens once: pushes that follow are kept.
- R5: A control write with bits 0 and 2 both set empties the transmit queue and leaves the receive queue alone. The flush happens once: pushes that follow are kept.
- R6: Bits 7:6 of an enabling write select the receive trigger: 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14. `rx_irq` is high while the receive level is at or above the trigger.
- R7: While disabled, each queue holds at most one byte, so a second push is dropped. `rx_irq` is high whenever one byte is present.
- R8: In normal mode (bit 3 = 0, or queues disabled), `rx_rdy` is high while the receive level is nonzero, and `tx_rdy` is high only while the transmit queue is empty.
- R9: In DMA mode (bits 0 and 3 set), `rx_rdy` rises when the receive level reaches the trigger and stays high until the queue is empty. `tx_rdy` is high whenever the transmit queue is not full.
- R10: A push to a full receive queue is dropped, the stored bytes are kept, and `rx_overrun` is set. `rx_overrun` stays set until a receive flush command (R4) clears it.
- R11: A pop from an empty queue leaves the level at 0 and repeats the last popped byte on the data output.
- R12: A control write that changes bit 0, whether enabling or disabling, empties both queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte value |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_push_data | input | 8 | Byte from the receive shifter |
| rx_pop | input | 1 | Host reads a received byte |
| rx_pop_data | output | 8 | Byte read by the host, valid the cycle after `rx_pop` |
| rx_level | output | $clog2(DEPTH)+1 | Bytes held in the receive queue |
| rx_overrun | output | 1 | Sticky flag for a dropped receive byte |
| tx_push | input | 1 | Host writes a byte for transmission |
| tx_push_data | input | 8 | Byte written by the host |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_pop_data | output | 8 | Byte for the transmit shifter, valid the cycle after `tx_pop` |
| tx_level | output | $clog2(DEPTH)+1 | Bytes held in the transmit queue |
| rx_irq | output | 1 | Receive-data interrupt |
| rx_rdy | output | 1 | Receive ready, active high |
| tx_rdy | output | 1 | Transmit ready, active high |

## Verification
The bench builds the block with the default `DEPTH` of 16 and 8-bit data. At that depth, 16 pushes fill a queue, which is enough to test the full boundary, the overrun drop and the DMA-mode transmit ready. The 14-byte trigger sits two below full, so every trigger code and the DMA receive hysteresis (rising at 4 bytes, holding down to 1) can be tested with short directed sequences.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int BYTE_W = 8;

    // Control byte bit positions (software-visible, so fixed)
    localparam int CB_EN     = 0;
    localparam int CB_RXCLR  = 1;
    localparam int CB_TXCLR  = 2;
    localparam int CB_DMA    = 3;
    localparam int CB_TRG_LO = 6;
    localparam int CB_TRG_HI = 7;

    typedef enum logic [1:0] {
        TRG_ONE      = 2'b00,
        TRG_FOUR     = 2'b01,
        TRG_EIGHT    = 2'b10,
        TRG_FOURTEEN = 2'b11
    } rx_trig_e;

    typedef struct packed {
        logic     en;
        logic     dma;
        rx_trig_e trig;
    } fifo_cfg_t;

    function automatic int unsigned trig_bytes(input rx_trig_e t);
        case (t)
            TRG_ONE:   return 1;
            TRG_FOUR:  return 4;
            TRG_EIGHT: return 8;
            default:   return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
    import uart_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output fifo_cfg_t         cfg,
    output logic              rx_cmd_clr,
    output logic              tx_cmd_clr,
    output logic              en_flush
);

    logic unused_rsvd;
    assign unused_rsvd = ^wdata[5:4];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{en: 1'b0, dma: 1'b0, trig: TRG_ONE};
        end else if (we) begin
            cfg.en <= wdata[CB_EN];
            if (wdata[CB_EN]) begin
                cfg.dma  <= wdata[CB_DMA];
                cfg.trig <= rx_trig_e'(wdata[CB_TRG_HI:CB_TRG_LO]);
            end
        end
    end

    // Flush commands are single-cycle pulses: nothing is stored, so they self-clear
    assign rx_cmd_clr = we && wdata[CB_EN] && wdata[CB_RXCLR];
    assign tx_cmd_clr = we && wdata[CB_EN] && wdata[CB_TXCLR];
    assign en_flush   = we && (wdata[CB_EN] != cfg.en);

endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             single,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     pop_data,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             drop
);

    logic [W-1:0]     mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [LVL_W-1:0] cap;
    logic             push_ok, pop_ok;

    assign cap     = single ? LVL_W'(1) : LVL_W'(DEPTH);
    assign full    = (level >= cap);
    assign push_ok = push && !full;
    assign pop_ok  = pop && (level != '0);
    assign drop    = push && full && !clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            level    <= '0;
            pop_data <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push_ok) begin
                mem[wptr] <= push_data;
                wptr      <= wptr + 1'b1;
            end
            if (pop_ok) begin
                pop_data <= mem[rptr];
                rptr     <= rptr + 1'b1;
            end
            level <= level + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
    end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_push_data,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_pop_data,
    output logic [LVL_W-1:0]  rx_level,
    output logic              rx_overrun,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_push_data,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_pop_data,
    output logic [LVL_W-1:0]  tx_level,
    output logic              rx_irq,
    output logic              rx_rdy,
    output logic              tx_rdy
);

    fifo_cfg_t        cfg_q;
    logic             rx_cmd_clr, tx_cmd_clr, en_flush;
    logic             rx_full, tx_full, rx_drop, tx_drop;
    logic             dma_act, rx_has, rx_at_trig, dma_hold;
    logic [LVL_W-1:0] trig_lvl;
    logic             unused_tx;

    uart_fifo_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .wdata      (cfg_wdata),
        .cfg        (cfg_q),
        .rx_cmd_clr (rx_cmd_clr),
        .tx_cmd_clr (tx_cmd_clr),
        .en_flush   (en_flush)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .clr       (rx_cmd_clr || en_flush),
        .single    (!cfg_q.en),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .pop_data  (rx_pop_data),
        .level     (rx_level),
        .full      (rx_full),
        .drop      (rx_drop)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .clr       (tx_cmd_clr || en_flush),
        .single    (!cfg_q.en),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .level     (tx_level),
        .full      (tx_full),
        .drop      (tx_drop)
    );

    assign unused_tx = rx_full ^ tx_drop;

    // Sticky overrun, cleared only by an explicit receive flush command
    always_ff @(posedge clk) begin
        if (rst)             rx_overrun <= 1'b0;
        else if (rx_cmd_clr) rx_overrun <= 1'b0;
        else if (rx_drop)    rx_overrun <= 1'b1;
    end

    assign trig_lvl   = LVL_W'(trig_bytes(cfg_q.trig));
    assign dma_act    = cfg_q.en && cfg_q.dma;
    assign rx_has     = (rx_level != '0);
    assign rx_at_trig = cfg_q.en ? (rx_level >= trig_lvl) : rx_has;

    assign rx_irq = rx_at_trig;
    assign rx_rdy = dma_act ? (rx_has && (dma_hold || rx_at_trig)) : rx_has;
    assign tx_rdy = dma_act ? !tx_full : (tx_level == '0);

    // DMA receive hysteresis: once ready, hold until drained
    always_ff @(posedge clk) begin
        if (rst) dma_hold <= 1'b0;
        else     dma_hold <= dma_act && rx_rdy;
    end

endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [7:0]       cfg_wdata,
    input logic             en_q,
    input logic             rx_push,
    input logic             rx_pop,
    input logic [7:0]       rx_pop_data,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] tx_level,
    input logic             rx_overrun
);

    // R2
    rx_depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rx_level <= LVL_W'(DEPTH));

    // R7
    single_byte_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> rx_level <= LVL_W'(1));

    // R4
    rx_flush_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_wdata[0] && cfg_wdata[1] |=> rx_level == '0);

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rx_overrun && !(cfg_we && cfg_wdata[0] && cfg_wdata[1]) |=> rx_overrun);

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        rx_pop && rx_level == '0 && !rx_push && !cfg_we
        |=> rx_level == '0 && $stable(rx_pop_data));

    // R12
    enable_flush_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we && (cfg_wdata[0] != en_q) |=> rx_level == '0 && tx_level == '0);

endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .en_q        (cfg_q.en),
    .rx_push     (rx_push),
    .rx_pop      (rx_pop),
    .rx_pop_data (rx_pop_data),
    .rx_level    (rx_level),
    .tx_level    (tx_level),
    .rx_overrun  (rx_overrun)
);

// File: tb/uart_fifo_ctl_tb.sv
module uart_fifo_ctl_tb;

    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_we;
    logic [7:0]       cfg_wdata;
    logic             rx_push, rx_pop, tx_push, tx_pop;
    logic [7:0]       rx_push_data, tx_push_data;
    logic [7:0]       rx_pop_data, tx_pop_data;
    logic [LVL_W-1:0] rx_level, tx_level;
    logic             rx_overrun, rx_irq, rx_rdy, tx_rdy;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    uart_fifo_ctl #(.DEPTH(DEPTH)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .rx_push      (rx_push),
        .rx_push_data (rx_push_data),
        .rx_pop       (rx_pop),
        .rx_pop_data  (rx_pop_data),
        .rx_level     (rx_level),
        .rx_overrun   (rx_overrun),
        .tx_push      (tx_push),
        .tx_push_data (tx_push_data),
        .tx_pop       (tx_pop),
        .tx_pop_data  (tx_pop_data),
        .tx_level     (tx_level),
        .rx_irq       (rx_irq),
        .rx_rdy       (rx_rdy),
        .tx_rdy       (tx_rdy)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Each bus task spends one cycle: drive at negedge, edge, return at next negedge
    task automatic cfg_wr(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rx_in(input logic [7:0] d);
        rx_push = 1'b1; rx_push_data = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic rx_out();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic tx_in(input logic [7:0] d);
        tx_push = 1'b1; tx_push_data = d;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic tx_out();
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rx_level", int'(rx_level), 0);
        check("R1 tx_level", int'(tx_level), 0);
        check("R1 rx_irq", int'(rx_irq), 0);
        check("R1 rx_rdy", int'(rx_rdy), 0);
        check("R1 tx_rdy", int'(tx_rdy), 1);
        check("R1 rx_overrun", int'(rx_overrun), 0);
    endtask

    task automatic t_disabled();
        cfg_wr(8'hC8);                      // bit0 clear: dma/trigger 14 not programmed
        rx_in(8'h11);
        check("R3 irq at one byte", int'(rx_irq), 1);
        check("R3 rx_rdy normal", int'(rx_rdy), 1);
        rx_in(8'h22);
        check("R7 rx level capped", int'(rx_level), 1);
        check("R7 second byte overrun", int'(rx_overrun), 1);
        rx_out();
        check("R7 held byte", int'(rx_pop_data), 8'h11);
        tx_in(8'hA5);
        check("R8 tx_rdy low when holding", int'(tx_rdy), 0);
        tx_in(8'h5A);
        check("R7 tx level capped", int'(tx_level), 1);
        tx_out();
        check("R7 tx held byte", int'(tx_pop_data), 8'hA5);
    endtask

    task automatic t_enable_flush();
        rx_in(8'h33);
        tx_in(8'h44);
        cfg_wr(8'h01);
        check("R12 enable flushes rx", int'(rx_level), 0);
        check("R12 enable flushes tx", int'(tx_level), 0);
        check("R10 overrun kept", int'(rx_overrun), 1);
        cfg_wr(8'h03);
        check("R10 overrun cleared", int'(rx_overrun), 0);
    endtask

    task automatic t_order_overrun();
        for (int i = 0; i < DEPTH; i++) rx_in(8'(i * 7 + 3));
        check("R2 full level", int'(rx_level), DEPTH);
        rx_in(8'hEE);
        check("R10 level unchanged", int'(rx_level), DEPTH);
        check("R10 overrun set", int'(rx_overrun), 1);
        for (int i = 0; i < DEPTH; i++) begin
            rx_out();
            check("R2 order", int'(rx_pop_data), (i * 7 + 3) & 8'hFF);
        end
        check("R2 drained", int'(rx_level), 0);
        rx_out();
        check("R11 empty pop level", int'(rx_level), 0);
        check("R11 empty pop data", int'(rx_pop_data), ((DEPTH - 1) * 7 + 3) & 8'hFF);
    endtask

    task automatic t_triggers();
        int lv [4] = '{1, 4, 8, 14};
        for (int c = 0; c < 4; c++) begin
            cfg_wr(8'(8'h03 | (c << 6)));
            for (int n = 1; n <= lv[c]; n++) begin
                rx_in(8'(n));
                if (n == lv[c] - 1) check("R6 irq below trigger", int'(rx_irq), 0);
            end
            check("R6 irq at trigger", int'(rx_irq), 1);
        end
    endtask

    task automatic t_flush_cmds();
        cfg_wr(8'h07);
        rx_in(8'h01); rx_in(8'h02); rx_in(8'h03);
        tx_in(8'h10); tx_in(8'h20);
        cfg_wr(8'h03);
        check("R4 rx flushed", int'(rx_level), 0);
        check("R4 tx untouched", int'(tx_level), 2);
        rx_in(8'h04);
        check("R4 self-clearing", int'(rx_level), 1);
        cfg_wr(8'h05);
        check("R5 tx flushed", int'(tx_level), 0);
        check("R5 rx untouched", int'(rx_level), 1);
        tx_in(8'h30);
        check("R5 self-clearing", int'(tx_level), 1);
    endtask

    task automatic t_normal_rdy();
        cfg_wr(8'h07);
        check("R8 rx_rdy empty", int'(rx_rdy), 0);
        check("R8 tx_rdy empty", int'(tx_rdy), 1);
        rx_in(8'h55);
        check("R8 rx_rdy one byte", int'(rx_rdy), 1);
        tx_in(8'h66);
        check("R8 tx_rdy not empty", int'(tx_rdy), 0);
    endtask

    task automatic t_dma();
        cfg_wr(8'h4F);                      // enable, flush both, DMA, trigger 4
        rx_in(8'h01); rx_in(8'h02); rx_in(8'h03);
        check("R9 rx_rdy below trigger", int'(rx_rdy), 0);
        rx_in(8'h04);
        check("R9 rx_rdy at trigger", int'(rx_rdy), 1);
        rx_out(); rx_out(); rx_out();
        check("R9 rx_rdy held", int'(rx_rdy), 1);
        rx_out();
        check("R9 rx_rdy drops at empty", int'(rx_rdy), 0);
        for (int i = 0; i < DEPTH - 1; i++) tx_in(8'(i));
        check("R9 tx_rdy not full", int'(tx_rdy), 1);
        tx_in(8'hFF);
        check("R9 tx_rdy full", int'(tx_rdy), 0);
        tx_out();
        check("R9 tx_rdy after pop", int'(tx_rdy), 1);
    endtask

    initial begin
        rst = 1'b1;
        cfg_we = 1'b0; cfg_wdata = '0;
        rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
        rx_push_data = '0; tx_push_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_enable_flush();
        t_order_overrun();
        t_triggers();
        t_flush_cmds();
        t_normal_rdy();
        t_dma();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule